// File: doc/BRIEF.md
# Indirect Codec Control Register Bridge

This block connects a 32-bit host bus to a small private bank of 8-bit codec control registers. Software never addresses the bank directly. It sees only two words. The command word carries a register index, a data byte and a self-clearing write-go flag. The data word returns the byte of the selected register and an interrupt flag. A write starts when the host stores a command with the go flag set. The flag reads back as 1 until the internal write has finished. A read starts when the host stores a command with a new index and the go flag clear. The selected byte reaches the data word only after a fixed settling delay.

The bank holds 28 registers, each with its own reset value. Two test slots cannot be read or written. One slot is a status register. Two hardware pulse inputs set its ramp-complete flags, and the host clears them by writing zeros. The host side uses a plain single-cycle write strobe and a combinational read word. There are no stream interfaces and no back-pressure: the bus never stalls, and software must poll the go flag before it issues the next command.

Top module: `codec_reg_bridge`

## Requirements
- R1: The command word is at byte offset 0x0. It reads back as bit 16 = busy, bits 14:8 = current index and bits 7:0 = last accepted data byte, with all other bits 0. The data word is at byte offset 0x4.
- R2: A command write with bit 16 set makes busy read 1 for exactly 4 cycles. The byte is stored into the indexed register in the last of those cycles, and busy then reads 0.
- R3: A command write that arrives while busy is 1 is ignored completely: its index, data and go flag are all discarded.
- R4: A command write with bit 16 clear changes only the current index and data byte. No register is modified.
- R5: Bits 7:0 of the data word show the selected register 3 clock edges after an index-loading command. Until then they hold their previous value. Once settled, they follow the register.
- R6: After reset the registers hold, for index 0 to 27: 0c aa 78 00 00 ff 03 51 3f 00 00 04 04 04 04 04 04 0a 0a 00 00 00 c0 34 07 44 1f 00 (hex).
- R7: Indices 20, 21 and every index of 28 or above ignore writes and read as 0x00.
- R8: In register 9, bit 3 is set by a pulse on `ramp_up_pulse` and bit 2 by a pulse on `ramp_down_pulse`. A host write of 0 to such a bit clears it, and a write of 1 leaves it unchanged. When a clear and a set meet in the same cycle, the set wins. The other bits of register 9 are ordinary storage.
- R9: Bit 8 of the data word is the OR of status bits 3 and 2. It follows them with no settling delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_addr | input | 3 | Host byte offset (0x0 command, 0x4 data) |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Word at host_addr (combinational) |
| ramp_up_pulse | input | 1 | Sets status bit 3 of register 9 |
| ramp_down_pulse | input | 1 | Sets status bit 2 of register 9 |

## Verification
Directed tasks exercise the bridge with five kinds of command: index-only commands, go commands to ordinary slots, go commands that arrive while busy, go commands to hidden or out-of-range slots, and status clears mixed with hardware pulses. Cycle-exact sampling of the busy flag and the data byte separates a correct latency from one that is off by one. Writes of 1 versus 0 into the status register separate clear-only behaviour from plain storage. A neighbouring accessible slot is written next to the hidden slots, which shows that only the hidden slots are blocked.

// File: rtl/cdcbr_pkg.sv
package cdcbr_pkg;
  localparam int REG_CNT   = 28;
  localparam int IDX_W     = 7;
  localparam int VAL_W     = 8;
  localparam int STAT_IDX  = 9;
  localparam int UP_BIT    = 3;
  localparam int DN_BIT    = 2;
  localparam int HID_A     = 20;
  localparam int HID_B     = 21;
  localparam int GO_BIT    = 16;
  localparam int IDX_LSB   = 8;
  localparam int IRQ_BIT   = 8;

  function automatic logic [VAL_W-1:0] init_val(input int i);
    case (i)
      0:                   return 8'h0c;
      1:                   return 8'haa;
      2:                   return 8'h78;
      5:                   return 8'hff;
      6:                   return 8'h03;
      7:                   return 8'h51;
      8:                   return 8'h3f;
      11, 12, 13, 14, 15, 16: return 8'h04;
      17, 18:              return 8'h0a;
      22:                  return 8'hc0;
      23:                  return 8'h34;
      24:                  return 8'h07;
      25:                  return 8'h44;
      26:                  return 8'h1f;
      default:             return 8'h00;
    endcase
  endfunction

  function automatic logic reachable(input int i);
    return (i < REG_CNT) && (i != HID_A) && (i != HID_B);
  endfunction
endpackage

// File: rtl/cdcbr_cmd_seq.sv
module cdcbr_cmd_seq #(
  parameter int IDX_W  = 7,
  parameter int VAL_W  = 8,
  parameter int WR_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             go_in,
  input  logic [IDX_W-1:0] idx_in,
  input  logic [VAL_W-1:0] val_in,
  output logic             busy,
  output logic [IDX_W-1:0] idx_q,
  output logic [VAL_W-1:0] val_q,
  output logic             accepted,
  output logic             commit
);
  localparam int CW = $clog2(WR_LAT + 1);

  logic [CW-1:0] cnt;

  assign accepted = cmd_wr && !busy;
  assign commit   = busy && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      idx_q <= '0;
      val_q <= '0;
    end else if (accepted) begin
      idx_q <= idx_in;
      val_q <= val_in;
      if (go_in) begin
        busy <= 1'b1;
        cnt  <= CW'(WR_LAT);
      end
    end else if (busy) begin
      if (cnt == CW'(1)) busy <= 1'b0;
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/cdcbr_rd_path.sv
module cdcbr_rd_path #(
  parameter int VAL_W  = 8,
  parameter int RD_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [VAL_W-1:0] sel_val,
  output logic [VAL_W-1:0] rd_q
);
  localparam int CW = $clog2(RD_LAT + 1);

  logic [CW-1:0] settle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settle <= '0;
      rd_q   <= '0;
    end else begin
      if (reload)                settle <= CW'(RD_LAT);
      else if (settle != '0)     settle <= settle - CW'(1);
      if (settle <= CW'(1))      rd_q   <= sel_val;
    end
  end
endmodule

// File: rtl/cdcbr_bank.sv
module cdcbr_bank
  import cdcbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VAL_W-1:0] wr_val,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             up_set,
  input  logic             dn_set,
  output logic [VAL_W-1:0] rd_val,
  output logic             up_flag,
  output logic             dn_flag
);
  localparam int SEL_W = $clog2(REG_CNT);
  localparam logic [VAL_W-1:0] FLAG_MASK = VAL_W'((1 << UP_BIT) | (1 << DN_BIT));

  logic [VAL_W-1:0] regs [REG_CNT];

  for (genvar i = 0; i < REG_CNT; i++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));
    if (i == STAT_IDX) begin : g_stat
      logic [VAL_W-1:0] q;
      logic [VAL_W-1:0] sets;
      assign sets = VAL_W'({up_set, dn_set} << DN_BIT);
      always_ff @(posedge clk) begin
        if (!rst_n) q <= init_val(i);
        else if (hit)
          q <= (wr_val & ~FLAG_MASK) | (q & wr_val & FLAG_MASK) | sets;
        else
          q <= q | sets;
      end
      assign regs[i] = q;
    end else if (reachable(i)) begin : g_plain
      logic [VAL_W-1:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= init_val(i);
        else if (hit) q <= wr_val;
      end
      assign regs[i] = q;
    end else begin : g_hidden
      assign regs[i] = '0;
    end
  end

  assign rd_val  = (rd_idx < IDX_W'(REG_CNT)) ? regs[rd_idx[SEL_W-1:0]] : '0;
  assign up_flag = regs[STAT_IDX][UP_BIT];
  assign dn_flag = regs[STAT_IDX][DN_BIT];
endmodule

// File: rtl/codec_reg_bridge.sv
module codec_reg_bridge
  import cdcbr_pkg::*;
#(
  parameter int HADDR_W = 3,
  parameter int WR_LAT  = 4,
  parameter int RD_LAT  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               ramp_up_pulse,
  input  logic               ramp_down_pulse
);
  localparam logic [HADDR_W-1:0] CMD_OFS  = HADDR_W'(0);
  localparam logic [HADDR_W-1:0] DATA_OFS = HADDR_W'(4);

  logic             cmd_wr, busy, accepted, commit, irq, up_flag, dn_flag;
  logic [IDX_W-1:0] idx_q;
  logic [VAL_W-1:0] val_q, sel_val, rd_q;
  logic             unused_bits;

  assign cmd_wr      = host_wr && (host_addr == CMD_OFS);
  assign unused_bits = ^{host_wdata[31:GO_BIT+1], host_wdata[IDX_LSB+IDX_W]};

  cdcbr_cmd_seq #(.IDX_W(IDX_W), .VAL_W(VAL_W), .WR_LAT(WR_LAT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .go_in    (host_wdata[GO_BIT]),
    .idx_in   (host_wdata[IDX_LSB +: IDX_W]),
    .val_in   (host_wdata[VAL_W-1:0]),
    .busy     (busy),
    .idx_q    (idx_q),
    .val_q    (val_q),
    .accepted (accepted),
    .commit   (commit)
  );

  cdcbr_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (commit),
    .wr_idx  (idx_q),
    .wr_val  (val_q),
    .rd_idx  (idx_q),
    .up_set  (ramp_up_pulse),
    .dn_set  (ramp_down_pulse),
    .rd_val  (sel_val),
    .up_flag (up_flag),
    .dn_flag (dn_flag)
  );

  cdcbr_rd_path #(.VAL_W(VAL_W), .RD_LAT(RD_LAT)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (accepted),
    .sel_val (sel_val),
    .rd_q    (rd_q)
  );

  assign irq = up_flag | dn_flag;

  always_comb begin
    host_rdata = '0;
    if (host_addr == CMD_OFS) begin
      host_rdata[GO_BIT]             = busy;
      host_rdata[IDX_LSB +: IDX_W]   = idx_q;
      host_rdata[VAL_W-1:0]          = val_q;
    end else if (host_addr == DATA_OFS) begin
      host_rdata[IRQ_BIT]            = irq;
      host_rdata[VAL_W-1:0]          = rd_q;
    end
  end
endmodule

// File: rtl/codec_reg_bridge_chk.sv
module codec_reg_bridge_chk #(
  parameter int WR_LAT = 4,
  parameter int IDX_W  = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             commit,
  input logic             cmd_wr,
  input logic [IDX_W-1:0] idx_q,
  input logic             up_pulse,
  input logic             dn_pulse,
  input logic             up_flag,
  input logic             dn_flag,
  input logic             irq
);
  logic [15:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 16'd1;
    else           busy_len <= '0;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == 16'(WR_LAT)));

  p_commit_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> busy);

  p_ignore_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(idx_q));

  p_up_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    up_pulse |=> up_flag);

  p_dn_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_pulse |=> dn_flag);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_flag && !(commit && idx_q == IDX_W'(9))) |=> up_flag);

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse || dn_pulse) |=> irq);
endmodule

bind codec_reg_bridge codec_reg_bridge_chk #(.WR_LAT(WR_LAT), .IDX_W(cdcbr_pkg::IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .commit   (commit),
  .cmd_wr   (cmd_wr),
  .idx_q    (idx_q),
  .up_pulse (ramp_up_pulse),
  .dn_pulse (ramp_down_pulse),
  .up_flag  (up_flag),
  .dn_flag  (dn_flag),
  .irq      (irq)
);

// File: tb/codec_reg_bridge_tb_top.sv
module codec_reg_bridge_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        up_p = 1'b0;
  logic        dn_p = 1'b0;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  codec_reg_bridge dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_wr         (host_wr),
    .host_addr       (host_addr),
    .host_wdata      (host_wdata),
    .host_rdata      (host_rdata),
    .ramp_up_pulse   (up_p),
    .ramp_down_pulse (dn_p)
  );

  function automatic logic [7:0] exp_init(input int i);
    logic [7:0] t [28] = '{8'h0c, 8'haa, 8'h78, 8'h00, 8'h00, 8'hff, 8'h03, 8'h51,
                           8'h3f, 8'h00, 8'h00, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04,
                           8'h04, 8'h0a, 8'h0a, 8'h00, 8'h00, 8'h00, 8'hc0, 8'h34,
                           8'h07, 8'h44, 8'h1f, 8'h00};
    return t[i];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic cmd(input int idx, input int val, input bit go);
    host_addr  = 3'd0;
    host_wdata = {15'b0, go, 1'b0, 7'(idx), 8'(val)};
    host_wr    = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr    = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
  endtask

  task automatic get_reg(input int idx, output logic [31:0] v);
    cmd(idx, 0, 1'b0);
    tick(3);
    peek(3'd4, v);
  endtask

  task automatic pulse(input bit up);
    if (up) up_p = 1'b1; else dn_p = 1'b1;
    @(posedge clk); @(negedge clk);
    up_p = 1'b0; dn_p = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    peek(3'd0, v); check("R1 reset command word", v, 32'h0);
    peek(3'd4, v); check("R6 reset data word idx0", v, 32'h0c);
  endtask

  task automatic t_defaults();
    logic [31:0] v;
    for (int i = 0; i < 28; i++) begin
      get_reg(i, v);
      if (i == 20 || i == 21) check("R7 hidden reads zero", v, 32'h0);
      else                    check("R6 reset value", v, {24'b0, exp_init(i)});
    end
  endtask

  task automatic t_latency();
    logic [31:0] v;
    get_reg(0, v);
    cmd(1, 0, 1'b0);
    peek(3'd4, v); check("R5 hold at edge 0", v, 32'h0c);
    tick(1); peek(3'd4, v); check("R5 hold at edge 1", v, 32'h0c);
    tick(1); peek(3'd4, v); check("R5 hold at edge 2", v, 32'h0c);
    tick(1); peek(3'd4, v); check("R5 valid at edge 3", v, 32'haa);
  endtask

  task automatic t_write();
    logic [31:0] v;
    cmd(2, 8'h5a, 1'b1);
    peek(3'd0, v); check("R1 command readback", v, 32'h0001_025a);
    for (int k = 1; k <= 3; k++) begin
      tick(1); peek(3'd0, v); check("R2 busy held", {31'b0, v[16]}, 32'h1);
    end
    tick(1); peek(3'd0, v); check("R2 busy cleared after 4", {31'b0, v[16]}, 32'h0);
    tick(1); peek(3'd4, v); check("R2 value stored", v, 32'h5a);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    cmd(3, 8'h11, 1'b1);
    cmd(4, 8'h22, 1'b1);
    peek(3'd0, v); check("R3 command while busy ignored", v, 32'h0001_0311);
    tick(4);
    get_reg(3, v); check("R3 first write kept", v, 32'h11);
    get_reg(4, v); check("R3 second write dropped", v, 32'h00);
  endtask

  task automatic t_index_only();
    logic [31:0] v;
    cmd(5, 8'h00, 1'b0);
    tick(4);
    peek(3'd0, v); check("R4 no busy on index load", v, 32'h0000_0500);
    peek(3'd4, v); check("R4 register untouched", v, 32'hff);
  endtask

  task automatic t_hidden();
    logic [31:0] v;
    cmd(20, 8'h77, 1'b1); tick(4);
    get_reg(20, v); check("R7 idx20 write dropped", v, 32'h0);
    cmd(21, 8'h66, 1'b1); tick(4);
    get_reg(21, v); check("R7 idx21 write dropped", v, 32'h0);
    cmd(30, 8'h55, 1'b1); tick(4);
    get_reg(30, v); check("R7 out of range reads zero", v, 32'h0);
    cmd(19, 8'h77, 1'b1); tick(4);
    get_reg(19, v); check("R7 neighbour idx19 writable", v, 32'h77);
  endtask

  task automatic t_status();
    logic [31:0] v;
    get_reg(9, v); check("R9 no irq at start", v, 32'h0);
    pulse(1'b1);
    peek(3'd4, v); check("R9 irq immediate", {31'b0, v[8]}, 32'h1);
    tick(1); peek(3'd4, v); check("R8 ramp-up sets bit3", v, 32'h108);
    cmd(9, 8'h00, 1'b1); tick(5);
    peek(3'd4, v); check("R8 write 0 clears", v, 32'h0);
    pulse(1'b0); tick(1);
    peek(3'd4, v); check("R8 ramp-down sets bit2", v, 32'h104);
    cmd(9, 8'h0c, 1'b1); tick(5);
    peek(3'd4, v); check("R8 write 1 no effect", v, 32'h104);
    cmd(9, 8'h40, 1'b1); tick(5);
    peek(3'd4, v); check("R8 plain bits store, flags clear", v, 32'h040);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_defaults();
    t_latency();
    t_write();
    t_busy_ignore();
    t_index_only();
    t_hidden();
    t_status();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule